// File: doc/BRIEF.md
# Binary64 Truncating Floating-Point Multiplier

This block takes two 64-bit IEEE-754 double-precision operands and returns their product in the same format, along with flags for an exponent that is too large or too small to represent. Each operand is split into its sign, biased exponent and fraction, and the implicit leading one is put back in front of the fraction. The two 53-bit significands are multiplied by a carry-save adder array. A ripple-carry adder then resolves that array's sum and carry vectors into the 106-bit product.

The exponent path adds the two biased exponents, removes one bias, and adds one more when the product has to be shifted right by one place to normalise it. Fraction bits below the retained 52 are dropped, so rounding is by truncation. The block expects normalised operands and does not handle infinities, NaNs or subnormal inputs specially. An exponent above the largest finite code gives a signed infinity. An exponent below the smallest normal code gives a signed zero.

Each accepted operand pair produces a registered result, with a matching valid, exactly one clock later. A new pair can be accepted on every cycle.

Top module: `fpm_mul64`

## Requirements
- R1: The operand layout is bit 63 = sign, bits 62:52 = biased exponent, bits 51:0 = fraction. The result uses the same layout, and its sign is the XOR of the two operand signs.
- R2: For an in-range result, the result exponent equals ea + eb - 1023, plus 1 when the product of the significands is 2.0 or more.
- R3: The 106-bit product of the significands, each with its hidden one restored, has its leading one at bit 105 or bit 104. The result fraction is the 52 bits just below that leading one, and all lower bits are discarded (truncation).
- R4: When the normalised biased exponent exceeds 2046, ovf is 1 and the result is a signed infinity: exponent field all ones, fraction zero.
- R5: When the normalised biased exponent is below 1, unf is 1 and the result is a signed zero: bits 62:0 are zero.
- R6: out_valid is 1 in the cycle after a cycle with in_valid high, and 0 in the cycle after a cycle with in_valid low. result, ovf and unf are updated only for accepted operand pairs.
- R7: While rst is high, and in the first cycle after it is released, out_valid, result, ovf and unf are all zero.
- R8: ovf and unf are never both 1. Both are 0 when the normalised exponent lies within 1..2046, including the end values 1 and 2046.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on op_a/op_b are to be multiplied |
| op_a | input | 64 | First binary64 operand |
| op_b | input | 64 | Second binary64 operand |
| out_valid | output | 1 | result and flags hold a new product |
| result | output | 64 | Binary64 product, truncated |
| ovf | output | 1 | Exponent overflow, result is signed infinity |
| unf | output | 1 | Exponent underflow, result is signed zero |

## Verification
Every output of this block is due exactly one rising edge after the edge that accepts its operands: result, ovf, unf and out_valid all come from one register stage. The bench drives a pair on a falling edge and computes the expected product from a behavioural integer multiply. It checks out_valid, result and both flags on the next falling edge, which lies half a period after the capturing edge. Idle cycles are checked in the same way, and there out_valid must be low. Exponent boundaries at 1 and 2046 are checked both with and without the extra normalisation increment.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    localparam int WORD_W  = 64;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int EXT_W   = EXP_W + 2;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXP_W) - 2;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_t;

    typedef enum logic [1:0] {
        KIND_NORMAL = 2'd0,
        KIND_OVF    = 2'd1,
        KIND_UNF    = 2'd2
    } res_kind_e;

    function automatic logic [SIG_W-1:0] full_sig(fp_t x);
        return {1'b1, x.frac};
    endfunction

    function automatic logic signed [EXT_W-1:0] widen_exp(logic [EXP_W-1:0] e);
        return signed'({2'b00, e});
    endfunction
endpackage

// File: rtl/fpm_sig_mult.sv
module fpm_sig_mult #(
    parameter int N = 53
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] prod
);
    localparam int PW = 2 * N;

    // partial product rows: AND array, each row placed at its weight
    logic [PW-1:0] pp [N];

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_pp
            assign pp[gi] = b[gi] ? (PW'(a) << gi) : '0;
        end
    endgenerate

    // carry-save rows, then a ripple-carry resolve
    always_comb begin
        logic [PW-1:0] s_vec;
        logic [PW-1:0] c_vec;
        logic [PW-1:0] ns;
        logic [PW-1:0] nc;
        logic          cy;
        s_vec = pp[0];
        c_vec = '0;
        for (int i = 1; i < N; i++) begin
            ns    = s_vec ^ c_vec ^ pp[i];
            nc    = ((s_vec & c_vec) | (s_vec & pp[i]) | (c_vec & pp[i])) << 1;
            s_vec = ns;
            c_vec = nc;
        end
        cy = 1'b0;
        for (int k = 0; k < PW; k++) begin
            prod[k] = s_vec[k] ^ c_vec[k] ^ cy;
            cy      = (s_vec[k] & c_vec[k]) | (cy & (s_vec[k] ^ c_vec[k]));
        end
    end
endmodule

// File: rtl/fpm_norm.sv
module fpm_norm
    import fpm_pkg::*;
(
    input  logic [PROD_W-1:0]       prod,
    input  logic signed [EXT_W-1:0] exp_raw,
    input  logic                    sign,
    output fp_t                     res,
    output res_kind_e               kind
);
    localparam logic signed [EXT_W-1:0] TOP_X = EXT_W'(EXP_TOP);
    localparam logic signed [EXT_W-1:0] ONE_X = EXT_W'(1);

    logic                    hi;
    logic signed [EXT_W-1:0] exp_n;
    logic [FRAC_W-1:0]       frac_t;

    assign hi     = prod[PROD_W-1];
    assign exp_n  = exp_raw + (hi ? ONE_X : '0);
    assign frac_t = hi ? prod[PROD_W-2 -: FRAC_W] : prod[PROD_W-3 -: FRAC_W];

    always_comb begin
        res.sign = sign;
        if (exp_n > TOP_X) begin
            kind     = KIND_OVF;
            res.exp  = '1;
            res.frac = '0;
        end else if (exp_n < ONE_X) begin
            kind     = KIND_UNF;
            res.exp  = '0;
            res.frac = '0;
        end else begin
            kind     = KIND_NORMAL;
            res.exp  = exp_n[EXP_W-1:0];
            res.frac = frac_t;
        end
    end
endmodule

// File: rtl/fpm_mul64.sv
module fpm_mul64
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              ovf,
    output logic              unf
);
    localparam logic signed [EXT_W-1:0] BIAS_X = EXT_W'(BIAS);

    fp_t                     fa, fb, nres;
    logic [PROD_W-1:0]       prod;
    logic signed [EXT_W-1:0] exp_raw;
    res_kind_e               kind;

    assign fa      = fp_t'(op_a);
    assign fb      = fp_t'(op_b);
    assign exp_raw = widen_exp(fa.exp) + widen_exp(fb.exp) - BIAS_X;

    fpm_sig_mult #(.N(SIG_W)) u_mult (
        .a    (full_sig(fa)),
        .b    (full_sig(fb)),
        .prod (prod)
    );

    fpm_norm u_norm (
        .prod    (prod),
        .exp_raw (exp_raw),
        .sign    (fa.sign ^ fb.sign),
        .res     (nres),
        .kind    (kind)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            ovf       <= 1'b0;
            unf       <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= nres;
                ovf    <= (kind == KIND_OVF);
                unf    <= (kind == KIND_UNF);
            end
        end
    end

    // R3
    lead_one_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (prod[PROD_W-1 -: 2] != 2'b00));

    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R6
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R1
    sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (result[WORD_W-1] == $past(op_a[WORD_W-1] ^ op_b[WORD_W-1])));

    // R4
    ovf_inf_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (result[WORD_W-2 -: EXP_W] == '1 && result[FRAC_W-1:0] == '0));

    // R5
    unf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        unf |-> (result[WORD_W-2:0] == '0));

    // R8
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ovf && unf));
endmodule

// File: tb/sim_fpm_mul64.sv
`timescale 1ns/1ps
module sim_fpm_mul64;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        ovf;
    logic        unf;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        logic [65:0] exp;
        string       tag;
    } pend_t;

    pend_t q[$];
    bit    exp_valid = 1'b0;

    always #5 clk = ~clk;

    fpm_mul64 u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .out_valid(out_valid), .result(result), .ovf(ovf), .unf(unf)
    );

    // behavioural reference: {ovf, unf, result}
    function automatic logic [65:0] ref_mul(logic [63:0] a, logic [63:0] b);
        logic [105:0] ma, mb, p;
        logic         s;
        int           e;
        logic [51:0]  f;
        s  = a[63] ^ b[63];
        ma = {53'd0, 1'b1, a[51:0]};
        mb = {53'd0, 1'b1, b[51:0]};
        p  = ma * mb;
        e  = int'(a[62:52]) + int'(b[62:52]) - 1023;
        if (p[105]) begin
            e = e + 1;
            f = p[104:53];
        end else begin
            f = p[103:52];
        end
        if (e > 2046) return {2'b10, s, 11'h7FF, 52'd0};
        if (e < 1)    return {2'b01, s, 63'd0};
        return {2'b00, s, e[10:0], f};
    endfunction

    function automatic logic [63:0] mk(logic s, int e, logic [51:0] f);
        return {s, e[10:0], f};
    endfunction

    task automatic check_now();
        pend_t p;
        n_tests++;
        if (exp_valid) begin
            p = q.pop_front();
            if (out_valid !== 1'b1 || {ovf, unf, result} !== p.exp) begin
                n_fail++;
                $display("FAIL %s: got v=%b ovf=%b unf=%b res=%h exp v=1 ovf=%b unf=%b res=%h",
                         p.tag, out_valid, ovf, unf, result, p.exp[65], p.exp[64], p.exp[63:0]);
            end
        end else if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R6: idle got out_valid=%b exp 0", out_valid);
        end
    endtask

    task automatic step(bit v, logic [63:0] a, logic [63:0] b, string tag);
        pend_t p;
        @(negedge clk);
        check_now();
        in_valid = v;
        op_a     = a;
        op_b     = b;
        exp_valid = v;
        if (v) begin
            p.exp = ref_mul(a, b);
            p.tag = tag;
            q.push_back(p);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state while held
        n_tests++;
        if (out_valid !== 1'b0 || result !== 64'd0 || ovf !== 1'b0 || unf !== 1'b0) begin
            n_fail++;
            $display("FAIL R7: got v=%b res=%h ovf=%b unf=%b exp all zero", out_valid, result, ovf, unf);
        end
        rst = 1'b0;
        @(negedge clk);
        // R7: first cycle after release
        n_tests++;
        if (out_valid !== 1'b0 || result !== 64'd0 || ovf !== 1'b0 || unf !== 1'b0) begin
            n_fail++;
            $display("FAIL R7: after release got v=%b res=%h exp all zero", out_valid, result);
        end

        step(1, mk(0, 1023, 0), mk(0, 1023, 0), "R2 one_times_one");
        step(1, mk(0, 1023, 52'h8000000000000), mk(0, 1023, 52'h8000000000000), "R3 shift_case_1.5sq");
        step(1, mk(1, 1024, 52'h8000000000000), mk(0, 1025, 52'h4000000000000), "R1 neg_times_pos");
        step(1, mk(1, 1000, 52'h123456789ABCD), mk(1, 1040, 52'h0FEDCBA987654), "R1 neg_times_neg");
        step(1, mk(0, 1023, 52'hFFFFFFFFFFFFF), mk(0, 1023, 52'hFFFFFFFFFFFFF), "R3 truncation_all_ones");
        step(0, 0, 0, "");
        step(1, mk(0, 1023, 52'h5555555555555), mk(0, 1023, 52'h3333333333333), "R3 no_shift_pattern");
        step(1, mk(0, 2046, 0), mk(0, 1023, 0), "R8 top_exp_2046");
        step(1, mk(1, 2046, 0), mk(0, 1024, 0), "R4 over_by_one");
        step(1, mk(0, 2046, 52'h8000000000000), mk(0, 1023, 52'h8000000000000), "R4 over_via_norm");
        step(1, mk(0, 1, 0), mk(0, 1023, 0), "R8 bottom_exp_1");
        step(1, mk(1, 1, 0), mk(0, 1022, 0), "R5 under_by_one");
        step(1, mk(0, 1, 52'h8000000000000), mk(0, 1022, 52'h8000000000000), "R2 norm_lifts_to_1");
        step(1, mk(0, 1800, 0), mk(1, 1800, 0), "R4 large_signed");
        step(1, mk(1, 200, 0), mk(1, 300, 0), "R5 small_signed");
        step(0, 0, 0, "");
        step(0, 0, 0, "");
        for (int i = 0; i < 300; i++) begin
            logic [63:0] ra, rb;
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            if (ra[62:52] == 0 || ra[62:52] == 11'h7FF) ra[62:52] = 11'd1023;
            if (rb[62:52] == 0 || rb[62:52] == 11'h7FF) rb[62:52] = 11'd700;
            step((i % 7) != 3, ra, rb, "R2 random");
        end
        step(0, 0, 0, "");
        @(negedge clk);
        check_now();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule